// File: doc/BRIEF.md
# NAND Data Transfer Executor

This block carries out the data phase of a NAND flash command sequence over an 8-bit flash bus. A sequencer hands it one instruction at a time: an opcode, a byte count and a starting buffer pointer. The block then moves bytes between the flash bus and a local page buffer, or moves a single byte through a mailbox. It generates the read and write strobes itself and holds the command-latch and address-latch enables low. It raises a one-cycle done pulse when the instruction ends.

Two buffer modes exist. A nonzero count moves that many bytes starting at the given pointer. A zero count moves one whole page, data plus spare area, starting at buffer address 0, and on completion fires an ECC hook: check for reads, store for writes. The ECC arithmetic itself lives outside the block. An external single-bit-corrected indication is latched into a sticky flag when a check is fired. Bytes whose buffer address falls past the spare area are still strobed on the bus, but a read does not store them and a write sends 0x00 for them.

The ready-waiting variants first sample the ready/busy input each cycle. If ready is not seen within a parameterised number of cycles, the instruction ends with a timeout flag and moves no data. The ready/busy input is expected to be synchronous to `clk`.

Top module: `nand_xfer_exec`

## Requirements
- R1: Opcode 0 (buffer read) with a nonzero count N produces N read-strobe pulses and stores the byte sampled on each pulse into buffer addresses bufPtr, bufPtr+1, ... in order.
- R2: A byte count of 0 on a buffer opcode (0, 1 or 4) moves PAGE_DATA+PAGE_SPARE bytes starting at address 0 regardless of bufPtr. At the done cycle, eccCheck pulses for a read or eccStore pulses for a write. sbcFlag is set if eccSingleFix is high during an eccCheck pulse, and is cleared when the next command is accepted.
- R3: On a buffer read, bytes whose address is at or past PAGE_DATA+PAGE_SPARE are strobed but never written to the buffer (ramWe stays low for them).
- R4: Opcode 4 (buffer write) with count N produces N write-strobe pulses. The bus carries the buffer bytes in address order. fDataOe is high while a write byte is on the bus, and fCle and fAle stay low throughout. The read and write strobes are never low together.
- R5: On a buffer write, bytes whose address is at or past PAGE_DATA+PAGE_SPARE are sent as 0x00.
- R6: Opcode 2 (status read) produces exactly one read strobe and a one-cycle mbInValid pulse carrying the sampled byte on mbInByte; the buffer is not written.
- R7: Opcode 5 (status write) produces exactly one write strobe carrying mbOutByte as it was when the command was accepted.
- R8: Opcodes 1 and 3 (ready-waiting buffer read and status read) produce no strobe until fReady is sampled high. After that they behave as opcodes 0 and 2.
- R9: If fReady stays low for TIMEOUT_CYC polled cycles, the instruction ends with a done pulse, no strobe, and timeoutFlag set in that done cycle. timeoutFlag stays set until the next command is accepted.
- R10: Each strobe is low for LOW_CYC clocks and high for at least HIGH_CYC clocks between bytes. Read data is sampled at the clock edge on which the strobe rises.
- R11: done is a one-cycle pulse per instruction and busy is high from acceptance through done. cmdValid is ignored while busy, and the strobes stay high while idle.
- R12: Opcodes 6 and 7 are ignored: no busy, no strobe, no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Instruction request, sampled when idle |
| cmdOp | input | 3 | Opcode (see R1–R12) |
| byteCount | input | CNT_W | Byte count for buffer opcodes; 0 selects a full page |
| bufPtr | input | ADDR_W | Starting buffer address for buffer opcodes |
| mbOutByte | input | 8 | Mailbox byte for status write |
| mbInByte | output | 8 | Byte captured by a status read |
| mbInValid | output | 1 | One-cycle qualifier for mbInByte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| timeoutFlag | output | 1 | Ready poll expired on the last instruction |
| eccCheck | output | 1 | ECC check hook, full-page read |
| eccStore | output | 1 | ECC store hook, full-page write |
| eccSingleFix | input | 1 | External single-bit-corrected indication |
| sbcFlag | output | 1 | Latched single-bit-corrected status |
| fReN | output | 1 | Flash read strobe, active low |
| fWeN | output | 1 | Flash write strobe, active low |
| fCle | output | 1 | Command-latch enable, held low |
| fAle | output | 1 | Address-latch enable, held low |
| fDataOut | output | 8 | Flash bus write data |
| fDataOe | output | 1 | Flash bus output enable |
| fDataIn | input | 8 | Flash bus read data |
| fReady | input | 1 | Flash ready/busy, high when ready |
| ramAddr | output | ADDR_W | Buffer RAM address (asynchronous read) |
| ramWe | output | 1 | Buffer RAM write enable |
| ramWdata | output | 8 | Buffer RAM write data |
| ramRdata | input | 8 | Buffer RAM read data for ramAddr |

## Verification
The bench targets the page-end boundary from both sides. A read that starts two bytes before the end of the spare area must strobe four times yet leave addresses 0 and 1 untouched; a design that wraps the pointer would overwrite them. A write in the same position must emit zeros, not stale or wrapped buffer bytes. The zero-count case is checked for a full page from address 0 with the ECC hook firing. A design that treats zero literally would end after no bytes. A design that honours bufPtr would shift the page. The ready poll is checked both for holding off the strobe until ready and for expiring at the parameterised cycle count. The bench also checks that a command arriving while busy does not change the transfer in progress.

// File: rtl/nand_xfer_pkg.sv
package nand_xfer_pkg;

  localparam logic [2:0] OP_BUF_RD      = 3'd0;
  localparam logic [2:0] OP_BUF_RD_WAIT = 3'd1;
  localparam logic [2:0] OP_STAT_RD     = 3'd2;
  localparam logic [2:0] OP_STAT_RD_WAIT= 3'd3;
  localparam logic [2:0] OP_BUF_WR      = 3'd4;
  localparam logic [2:0] OP_STAT_WR     = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_LO, S_HI, S_FIN
  } xfer_st_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // accept instruction, latch operands
    logic capture;     // sample flash bus on strobe rise
    logic ramWrite;    // store captured byte into buffer
    logic mbPulse;     // present captured byte on mailbox
    logic advance;     // byte finished, step pointer and count
    logic setTimeout;  // ready poll expired
    logic finish;      // instruction end cycle
  } xfer_ctl_t;

  function automatic logic opValid(input logic [2:0] op);
    return op <= OP_STAT_WR;
  endfunction

  function automatic logic opReads(input logic [2:0] op);
    return op <= OP_STAT_RD_WAIT;
  endfunction

  function automatic logic opWaits(input logic [2:0] op);
    return (op == OP_BUF_RD_WAIT) || (op == OP_STAT_RD_WAIT);
  endfunction

  function automatic logic opStat(input logic [2:0] op);
    return (op == OP_STAT_RD) || (op == OP_STAT_RD_WAIT) || (op == OP_STAT_WR);
  endfunction

endpackage

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl
  import nand_xfer_pkg::*;
#(
  parameter int LOW_CYC     = 2,
  parameter int HIGH_CYC    = 2,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       fReady,
  input  logic       lastByte,
  output xfer_ctl_t  ctl,
  output logic [2:0] opQ,
  output logic       busy,
  output logic       done,
  output logic       fReN,
  output logic       fWeN,
  output logic       fDataOe
);

  localparam int PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [PH_W-1:0] LO_LAST = PH_W'(LOW_CYC - 1);
  localparam logic [PH_W-1:0] HI_LAST = PH_W'(HIGH_CYC - 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

  xfer_st_e        st, stN;
  logic [PH_W-1:0] phase;
  logic [TO_W-1:0] pollCnt;
  logic            accept, loEnd, hiEnd, pollEnd, rdOp, statOp;

  assign accept  = (st == S_IDLE) && cmdValid && opValid(cmdOp);
  assign loEnd   = (st == S_LO) && (phase == LO_LAST);
  assign hiEnd   = (st == S_HI) && (phase == HI_LAST);
  assign pollEnd = (st == S_POLL) && !fReady && (pollCnt == TO_LAST);
  assign rdOp    = opReads(opQ);
  assign statOp  = opStat(opQ);

  always_comb begin
    stN = st;
    unique case (st)
      S_IDLE:  if (accept) stN = opWaits(cmdOp) ? S_POLL : S_LO;
      S_POLL:  if (fReady) stN = S_LO;
               else if (pollEnd) stN = S_FIN;
      S_LO:    if (loEnd) stN = S_HI;
      S_HI:    if (hiEnd) stN = lastByte ? S_FIN : S_LO;
      S_FIN:   stN = S_IDLE;
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      phase   <= '0;
      pollCnt <= '0;
      opQ     <= OP_BUF_RD;
    end else begin
      st <= stN;
      if (st != stN)
        phase <= '0;
      else if (st == S_LO || st == S_HI)
        phase <= phase + 1'b1;
      if (st == S_POLL)
        pollCnt <= pollCnt + 1'b1;
      else
        pollCnt <= '0;
      if (accept)
        opQ <= cmdOp;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = accept;
    ctl.capture    = loEnd && rdOp;
    ctl.ramWrite   = (st == S_HI) && (phase == '0) && rdOp && !statOp;
    ctl.mbPulse    = (st == S_HI) && (phase == '0) && rdOp && statOp;
    ctl.advance    = hiEnd;
    ctl.setTimeout = pollEnd;
    ctl.finish     = (st == S_FIN);
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign fReN    = !((st == S_LO) && rdOp);
  assign fWeN    = !((st == S_LO) && !rdOp);
  assign fDataOe = ((st == S_LO) || (st == S_HI)) && !rdOp;

endmodule

// File: rtl/nand_xfer_dp.sv
module nand_xfer_dp
  import nand_xfer_pkg::*;
#(
  parameter int PAGE_TOTAL = 528,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_ctl_t         ctl,
  input  logic [2:0]        cmdOp,
  input  logic [2:0]        opQ,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] bufPtr,
  input  logic [7:0]        mbOutByte,
  input  logic [7:0]        fDataIn,
  input  logic [7:0]        ramRdata,
  input  logic              eccSingleFix,
  output logic              lastByte,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  output logic [7:0]        fDataOut,
  output logic [7:0]        mbInByte,
  output logic              mbInValid,
  output logic              eccCheck,
  output logic              eccStore,
  output logic              sbcFlag,
  output logic              timeoutFlag
);

  // Pointer is wide enough that start + count never wraps
  localparam int PTR_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(PAGE_TOTAL);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_TOTAL);

  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] remaining;
  logic [7:0]       rdByte, mbHold;
  logic             fullQ, inRange, cntZero, newStat;

  assign cntZero = (byteCount == '0);
  assign newStat = opStat(cmdOp);
  assign inRange = (ptr < PTR_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr         <= '0;
      remaining   <= '0;
      rdByte      <= '0;
      mbHold      <= '0;
      fullQ       <= 1'b0;
      sbcFlag     <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      if (ctl.load) begin
        mbHold      <= mbOutByte;
        fullQ       <= !newStat && cntZero;
        sbcFlag     <= 1'b0;
        timeoutFlag <= 1'b0;
        if (newStat) begin
          remaining <= CNT_W'(1);
          ptr       <= '0;
        end else if (cntZero) begin
          remaining <= CNT_PAGE;
          ptr       <= '0;
        end else begin
          remaining <= byteCount;
          ptr       <= PTR_W'(bufPtr);
        end
      end else if (ctl.advance) begin
        ptr       <= ptr + 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (ctl.capture)
        rdByte <= fDataIn;
      if (ctl.setTimeout)
        timeoutFlag <= 1'b1;
      if (eccCheck && eccSingleFix)
        sbcFlag <= 1'b1;
    end
  end

  assign lastByte  = (remaining == CNT_W'(1));
  assign ramAddr   = ptr[ADDR_W-1:0];
  assign ramWe     = ctl.ramWrite && inRange;
  assign ramWdata  = rdByte;
  assign mbInByte  = rdByte;
  assign mbInValid = ctl.mbPulse;
  assign fDataOut  = opStat(opQ) ? mbHold : (inRange ? ramRdata : 8'h00);
  assign eccCheck  = ctl.finish && fullQ && opReads(opQ) && !timeoutFlag;
  assign eccStore  = ctl.finish && fullQ && !opReads(opQ);

endmodule

// File: rtl/nand_xfer_exec.sv
module nand_xfer_exec
  import nand_xfer_pkg::*;
#(
  parameter int PAGE_DATA   = 512,
  parameter int PAGE_SPARE  = 16,
  parameter int CNT_W       = 12,
  parameter int LOW_CYC     = 2,
  parameter int HIGH_CYC    = 2,
  parameter int TIMEOUT_CYC = 1000,
  localparam int PAGE_TOTAL = PAGE_DATA + PAGE_SPARE,
  localparam int ADDR_W     = $clog2(PAGE_TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] bufPtr,
  input  logic [7:0]        mbOutByte,
  output logic [7:0]        mbInByte,
  output logic              mbInValid,
  output logic              busy,
  output logic              done,
  output logic              timeoutFlag,
  output logic              eccCheck,
  output logic              eccStore,
  input  logic              eccSingleFix,
  output logic              sbcFlag,
  output logic              fReN,
  output logic              fWeN,
  output logic              fCle,
  output logic              fAle,
  output logic [7:0]        fDataOut,
  output logic              fDataOe,
  input  logic [7:0]        fDataIn,
  input  logic              fReady,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  xfer_ctl_t  ctl;
  logic [2:0] opQ;
  logic       lastByte;

  nand_xfer_ctrl #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .fReady(fReady), .lastByte(lastByte), .ctl(ctl), .opQ(opQ),
    .busy(busy), .done(done), .fReN(fReN), .fWeN(fWeN), .fDataOe(fDataOe)
  );

  nand_xfer_dp #(
    .PAGE_TOTAL(PAGE_TOTAL), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdOp(cmdOp), .opQ(opQ),
    .byteCount(byteCount), .bufPtr(bufPtr), .mbOutByte(mbOutByte),
    .fDataIn(fDataIn), .ramRdata(ramRdata), .eccSingleFix(eccSingleFix),
    .lastByte(lastByte), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramWdata(ramWdata), .fDataOut(fDataOut), .mbInByte(mbInByte),
    .mbInValid(mbInValid), .eccCheck(eccCheck), .eccStore(eccStore),
    .sbcFlag(sbcFlag), .timeoutFlag(timeoutFlag)
  );

  // Data-phase instructions never latch commands or addresses
  assign fCle = 1'b0;
  assign fAle = 1'b0;

endmodule

// File: rtl/nand_xfer_chk.sv
module nand_xfer_chk #(
  parameter int LOW_CYC    = 2,
  parameter int PAGE_TOTAL = 528,
  parameter int ADDR_W     = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              fReN,
  input logic              fWeN,
  input logic              fDataOe,
  input logic              busy,
  input logic              done,
  input logic              timeoutFlag,
  input logic              eccCheck,
  input logic              eccStore,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr
);

  localparam int LC_W = $clog2(LOW_CYC + 2);

  logic            anyLow;
  logic [LC_W-1:0] lowCnt;

  assign anyLow = !fReN || !fWeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lowCnt <= '0;
    else if (anyLow)
      lowCnt <= lowCnt + 1'b1;
    else
      lowCnt <= '0;
  end

  AST_STROBE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!anyLow && lowCnt != '0) |-> lowCnt == LC_W'(LOW_CYC)); // R10

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!fReN && !fWeN)); // R4

  AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    fDataOe |-> fReN); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (int'(ramAddr) < PAGE_TOTAL)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (fReN && fWeN && !done)); // R11

  AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> done); // R9

  AST_ECC_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (eccCheck || eccStore) |-> done); // R2

endmodule

bind nand_xfer_exec nand_xfer_chk #(
  .LOW_CYC(LOW_CYC), .PAGE_TOTAL(PAGE_TOTAL), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_nand_xfer_exec.sv
`timescale 1ns/1ps
module tb_nand_xfer_exec;

  localparam int PD = 512, PS = 16, PT = PD + PS;
  localparam int CW = 12, AW = 10;
  localparam int LOWC = 3, HIGHC = 2, TOC = 40;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0;
  logic [2:0] cmdOp = 0;
  logic [CW-1:0] byteCount = 0;
  logic [AW-1:0] bufPtr = 0;
  logic [7:0] mbOutByte = 0, fDataIn = 0, ramRdata;
  logic eccSingleFix = 0, fReady = 1;
  logic [7:0] mbInByte, fDataOut, ramWdata;
  logic mbInValid, busy, done, timeoutFlag, eccCheck, eccStore, sbcFlag;
  logic fReN, fWeN, fCle, fAle, fDataOe, ramWe;
  logic [AW-1:0] ramAddr;

  always #2.5 clk = ~clk;

  nand_xfer_exec #(
    .PAGE_DATA(PD), .PAGE_SPARE(PS), .CNT_W(CW),
    .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .TIMEOUT_CYC(TOC)
  ) dut (.*);

  // Buffer RAM model
  logic [7:0] mem [0:1023];
  assign ramRdata = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWdata;

  // Flash model and monitors
  int rdStrobes = 0, wrStrobes = 0, readIdx = 0, wrIdx = 0;
  int doneCnt = 0, chkCnt = 0, stoCnt = 0, mbCnt = 0, busViol = 0;
  logic [7:0] lastMb = 0, curWr = 0;
  logic [7:0] wrBytes [0:1023];
  realtime lowStart = 0, lowWidth = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(negedge fReN) begin
    fDataIn = pat(readIdx); readIdx++; rdStrobes++; lowStart = $realtime;
  end
  always @(posedge fReN) lowWidth = $realtime - lowStart;
  always @(negedge fWeN) wrStrobes++;
  always @(negedge clk) if (!fWeN) begin
    curWr = fDataOut;
    if (fCle || fAle || !fDataOe) busViol++;
  end
  always @(posedge fWeN) begin wrBytes[wrIdx] = curWr; wrIdx++; end
  always @(posedge clk) begin
    if (done) doneCnt++;
    if (eccCheck) chkCnt++;
    if (eccStore) stoCnt++;
    if (mbInValid) begin mbCnt++; lastMb = mbInByte; end
  end

  int nChecks = 0, nFails = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int cnt, input int ptr);
    @(negedge clk);
    cmdOp = op; byteCount = CW'(cnt); bufPtr = AW'(ptr); cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic run(input logic [2:0] op, input int cnt, input int ptr, output int cyc);
    int d0 = doneCnt;
    issue(op, cnt, ptr);
    cyc = 0;
    while (doneCnt == d0 && cyc < 20000) begin @(negedge clk); cyc++; end
    if (cyc >= 20000) check("watchdog", 0, 1);
  endtask

  task automatic t_reset;
    check("R11 reset busy", busy, 0);
    check("R11 reset done", done, 0);
    check("R11 reset fReN", fReN, 1);
    check("R11 reset fWeN", fWeN, 1);
    check("R9 reset timeoutFlag", timeoutFlag, 0);
  endtask

  task automatic t_buf_read;
    int r0 = rdStrobes, i0 = readIdx, d0 = doneCnt, cyc;
    run(3'd0, 4, 10, cyc);
    check("R1 read strobes", rdStrobes - r0, 4);
    for (int k = 0; k < 4; k++) check("R1 read data", mem[10+k], pat(i0 + k));
    check("R1 neighbour untouched", mem[14], 8'(14*3+1));
    check("R11 one done", doneCnt - d0, 1);
    check("R10 strobe low width ns", int'(lowWidth * 10), LOWC * 50);
  endtask

  task automatic t_read_overflow;
    int r0 = rdStrobes, i0 = readIdx, cyc;
    run(3'd0, 4, PT - 2, cyc);
    check("R3 overflow strobes", rdStrobes - r0, 4);
    check("R3 last in range", mem[PT-1], pat(i0 + 1));
    check("R3 addr0 kept", mem[0], 8'(1));
    check("R3 addr1 kept", mem[1], 8'(4));
  endtask

  task automatic t_full_read;
    int r0 = rdStrobes, i0 = readIdx, c0 = chkCnt, bad = 0, cyc;
    eccSingleFix = 1;
    run(3'd0, 0, 300, cyc);
    eccSingleFix = 0;
    for (int k = 0; k < PT; k++) if (mem[k] != pat(i0 + k)) bad++;
    check("R2 full read strobes", rdStrobes - r0, PT);
    check("R2 full read mismatches", bad, 0);
    check("R2 eccCheck pulses", chkCnt - c0, 1);
    check("R2 sbcFlag set", sbcFlag, 1);
  endtask

  task automatic t_buf_write;
    int w0 = wrStrobes, x0 = wrIdx, cyc;
    run(3'd4, 3, 20, cyc);
    check("R4 write strobes", wrStrobes - w0, 3);
    for (int k = 0; k < 3; k++) check("R4 write data", wrBytes[x0+k], mem[20+k]);
    check("R4 bus control", busViol, 0);
    check("R2 sbcFlag cleared", sbcFlag, 0);
  endtask

  task automatic t_write_overflow;
    int x0 = wrIdx, cyc;
    run(3'd4, 3, PT - 1, cyc);
    check("R5 last in range", wrBytes[x0], mem[PT-1]);
    check("R5 zero fill 1", wrBytes[x0+1], 0);
    check("R5 zero fill 2", wrBytes[x0+2], 0);
  endtask

  task automatic t_full_write;
    int w0 = wrStrobes, x0 = wrIdx, s0 = stoCnt, bad = 0, cyc;
    run(3'd4, 0, 77, cyc);
    for (int k = 0; k < PT; k++) if (wrBytes[x0+k] != mem[k]) bad++;
    check("R2 full write strobes", wrStrobes - w0, PT);
    check("R2 full write mismatches", bad, 0);
    check("R2 eccStore pulses", stoCnt - s0, 1);
  endtask

  task automatic t_status;
    int r0 = rdStrobes, w0 = wrStrobes, m0 = mbCnt, i0 = readIdx, x0 = wrIdx, cyc;
    logic [7:0] keep = mem[0];
    run(3'd2, 9, 0, cyc);
    check("R6 one read strobe", rdStrobes - r0, 1);
    check("R6 one mailbox pulse", mbCnt - m0, 1);
    check("R6 mailbox byte", lastMb, pat(i0));
    check("R6 buffer untouched", mem[0], keep);
    mbOutByte = 8'hA5;
    fork
      run(3'd5, 0, 0, cyc);
      begin repeat (3) @(negedge clk); mbOutByte = 8'h3C; end
    join
    check("R7 one write strobe", wrStrobes - w0, 1);
    check("R7 byte latched", wrBytes[x0], 8'hA5);
  endtask

  task automatic t_ready_wait;
    int r0 = rdStrobes, m0 = mbCnt, d0 = doneCnt, cyc;
    fReady = 0;
    issue(3'd3, 1, 0);
    repeat (10) @(negedge clk);
    check("R8 no strobe before ready", rdStrobes - r0, 0);
    fReady = 1;
    cyc = 0;
    while (doneCnt == d0 && cyc < 1000) begin @(negedge clk); cyc++; end
    check("R8 strobe after ready", rdStrobes - r0, 1);
    check("R8 mailbox after ready", mbCnt - m0, 1);
  endtask

  task automatic t_timeout;
    int r0 = rdStrobes, cyc;
    fReady = 0;
    run(3'd1, 0, 0, cyc);
    check("R9 timeout flag", timeoutFlag, 1);
    check("R9 no strobe", rdStrobes - r0, 0);
    check("R9 expiry cycles", (cyc >= TOC && cyc <= TOC + 3) ? 1 : 0, 1);
    fReady = 1;
    run(3'd2, 0, 0, cyc);
    check("R9 flag cleared", timeoutFlag, 0);
  endtask

  task automatic t_busy_ignore;
    int r0 = rdStrobes, w0 = wrStrobes, d0 = doneCnt;
    issue(3'd0, 4, 200);
    @(negedge clk);
    cmdOp = 3'd5; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
    repeat (60) @(negedge clk);
    check("R11 busy cmd ignored rd", rdStrobes - r0, 4);
    check("R11 busy cmd ignored wr", wrStrobes - w0, 0);
    check("R11 single done", doneCnt - d0, 1);
  endtask

  task automatic t_bad_op;
    int r0 = rdStrobes, w0 = wrStrobes, d0 = doneCnt;
    logic sawBusy = 0;
    issue(3'd6, 4, 0);
    issue(3'd7, 4, 0);
    repeat (10) begin @(negedge clk); if (busy) sawBusy = 1; end
    check("R12 no busy", sawBusy, 0);
    check("R12 no strobes", (rdStrobes - r0) + (wrStrobes - w0), 0);
    check("R12 no done", doneCnt - d0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_buf_read();
    t_read_overflow();
    t_full_read();
    t_buf_write();
    t_write_overflow();
    t_full_write();
    t_status();
    t_ready_wait();
    t_timeout();
    t_busy_ignore();
    t_bad_op();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule